// File: doc/BRIEF.md
# Delay-Compensated PWM With Mid-Pulse Current Sample Trigger

This block drives one PWM line into an H-bridge driver. The driver delays every output edge by a fixed amount and delays rising edges by a further, longer amount. Left alone, the pulse that reaches the load would be shorter than the one commanded. The block widens each commanded pulse by the rising-edge-only delay, so the delivered on-time equals the request. It also clamps the on-time and the off-time to a minimum. Both the commanded width and the period are taken only at the start of a period, so a pulse that is already running is never altered.

Alongside the drive, the block issues a one-cycle request to a current-sense converter. The request leads the midpoint of the delivered pulse by the converter's request latency, so the sample is taken at the true centre of the on-time. The converter needs a long round trip before it can accept another request. The block therefore keeps a busy window after each request. A request that falls inside that window is dropped, and the drop is counted in a saturating counter. A flag pulses when the window closes, which marks the point where the result can be taken. When settling suppression is enabled and the half-width is too short for the load current to settle, the request is withheld and a skip flag pulses in its place.

Top module: `pwm_trig`

## Requirements
- R1: While reset is high, `pwm_out`, `sample_req`, `sample_skipped` and `sample_valid` are 0 and `overrun_cnt` is 0. On the first clock after reset is released, a new period begins with `pwm_out` high.
- R2: A period lasts P cycles, where P is the clamped period. Within it, `pwm_out` is high from the period start for the clamped width plus 30 cycles and is low for the rest of the period.
- R3: The clamped period is `period_cmd`, raised to 160 if it is smaller. The clamped width is `width_cmd`, limited to the range 80 to P-80.
- R4: When the request is not suppressed, `sample_req` pulses once per period, at offset 25 + floor(clamped width / 2) from the period start. This offset is the delivered midpoint (37 + width/2) less the 12-cycle sense latency.
- R5: If `settle_en` is 1 and floor(clamped width / 2) is below 250, no request is made in that period. Instead, `sample_skipped` pulses for one cycle at the offset from R4. The flag never coincides with `sample_req`.
- R6: `width_cmd`, `period_cmd` and `settle_en` are sampled only at a period start. A change made during a period first acts in the next period.
- R7: After a request in cycle t, any request that falls due in cycles t+1 to t+799 is not issued and adds 1 to `overrun_cnt`. A request that falls due at t+800 is issued.
- R8: `overrun_cnt` counts up by 1 for each dropped request and holds at its all-ones value of 255.
- R9: `sample_valid` pulses for one cycle exactly 800 cycles after each issued request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 25 ns tick in the target system |
| rst | input | 1 | Synchronous active-high reset |
| width_cmd | input | 16 | Requested delivered on-width in ticks |
| period_cmd | input | 16 | Requested period in ticks |
| settle_en | input | 1 | Enable suppression of requests on short pulses |
| pwm_out | output | 1 | Drive to the H-bridge driver |
| sample_req | output | 1 | One-cycle current-sense request |
| sample_skipped | output | 1 | One-cycle flag: request withheld for settling |
| sample_valid | output | 1 | One-cycle flag: converter window has closed |
| overrun_cnt | output | 8 | Saturating count of dropped requests |

## Verification
The closing of one busy window and the next request can fall in the same cycle. This happens when the period is exactly 800 ticks, so the request due in the second period lands on the cycle where `sample_valid` fires. The bench sets up that case and checks two things in that single cycle. First, `sample_valid` is high and the new request is issued, not dropped. Second, `overrun_cnt` stays at 0. With a 500-tick period, every other request falls inside the window, so the drops and the saturation of the counter can be counted against hand-derived positions.

// File: rtl/pwm_trig_pkg.sv
`timescale 1ns/1ps
package pwm_trig_pkg;

    localparam int TW = 16;

    typedef struct packed {
        logic [TW-1:0] period;
        logic [TW-1:0] on_len;
        logic [TW-1:0] due;
        logic          skip;
    } cfg_t;

    // Turn raw commands into the per-period configuration
    function automatic cfg_t build_cfg(
        input logic [TW-1:0] w,
        input logic [TW-1:0] p,
        input logic          settle,
        input int unsigned   min_t,
        input int unsigned   comp,
        input int unsigned   lead,
        input int unsigned   settle_t
    );
        cfg_t          r;
        logic [TW-1:0] mn;
        logic [TW-1:0] pc;
        logic [TW-1:0] wc;
        logic [TW-1:0] half;
        mn = TW'(min_t);
        pc = (p < (mn << 1)) ? (mn << 1) : p;
        if (w < mn)
            wc = mn;
        else if (w > pc - mn)
            wc = pc - mn;
        else
            wc = w;
        half     = wc >> 1;
        r.period = pc;
        r.on_len = wc + TW'(comp);
        r.due    = half + TW'(lead);
        r.skip   = settle && (half < TW'(settle_t));
        return r;
    endfunction

endpackage

// File: rtl/pwm_trig_timebase.sv
`timescale 1ns/1ps
module pwm_trig_timebase
    import pwm_trig_pkg::*;
#(
    parameter int MIN_TICKS    = 80,
    parameter int RISE_COMP    = 30,
    parameter int LEAD         = 25,
    parameter int SETTLE_TICKS = 250
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] width_cmd,
    input  logic [TW-1:0] period_cmd,
    input  logic          settle_en,
    output logic          run,
    output logic [TW-1:0] cnt,
    output cfg_t          cfg
);

    cfg_t next_cfg;
    logic wrap;

    always_comb begin
        next_cfg = build_cfg(width_cmd, period_cmd, settle_en,
                             MIN_TICKS, RISE_COMP, LEAD, SETTLE_TICKS);
        wrap     = !run || (cnt == cfg.period - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
            cfg <= '0;
        end else if (wrap) begin
            run <= 1'b1;
            cnt <= '0;
            cfg <= next_cfg;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_trig_sched.sv
`timescale 1ns/1ps
module pwm_trig_sched #(
    parameter int BUSY_TICKS = 800,
    parameter int OVR_W      = 8,
    localparam int BW        = $clog2(BUSY_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             due,
    input  logic             skip,
    output logic             req,
    output logic             skipped,
    output logic             valid,
    output logic [OVR_W-1:0] overrun
);

    logic [BW-1:0] busy;
    logic          idle;
    logic          drop;

    always_comb begin
        idle    = (busy == '0);
        req     = due && !skip && idle;
        skipped = due && skip;
        drop    = due && !skip && !idle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= '0;
            valid   <= 1'b0;
            overrun <= '0;
        end else begin
            valid <= (busy == BW'(1));
            if (req)
                busy <= BW'(BUSY_TICKS - 1);
            else if (!idle)
                busy <= busy - 1'b1;
            if (drop && (overrun != {OVR_W{1'b1}}))
                overrun <= overrun + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_trig.sv
`timescale 1ns/1ps
module pwm_trig
    import pwm_trig_pkg::*;
#(
    parameter int RISE_COMP    = 30,
    parameter int EDGE_DLY     = 7,
    parameter int SENSE_LAT    = 12,
    parameter int MIN_TICKS    = 80,
    parameter int SETTLE_TICKS = 250,
    parameter int BUSY_TICKS   = 800,
    parameter int OVR_W        = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      width_cmd,
    input  logic [15:0]      period_cmd,
    input  logic             settle_en,
    output logic             pwm_out,
    output logic             sample_req,
    output logic             sample_skipped,
    output logic             sample_valid,
    output logic [OVR_W-1:0] overrun_cnt
);

    localparam int LEAD = EDGE_DLY + RISE_COMP - SENSE_LAT;

    logic          run;
    logic [TW-1:0] cnt;
    cfg_t          cfg;
    logic          due;

    pwm_trig_timebase #(
        .MIN_TICKS   (MIN_TICKS),
        .RISE_COMP   (RISE_COMP),
        .LEAD        (LEAD),
        .SETTLE_TICKS(SETTLE_TICKS)
    ) u_tb (
        .clk       (clk),
        .rst       (rst),
        .width_cmd (width_cmd),
        .period_cmd(period_cmd),
        .settle_en (settle_en),
        .run       (run),
        .cnt       (cnt),
        .cfg       (cfg)
    );

    always_comb begin
        pwm_out = run && (cnt < cfg.on_len);
        due     = run && (cnt == cfg.due);
    end

    pwm_trig_sched #(
        .BUSY_TICKS(BUSY_TICKS),
        .OVR_W     (OVR_W)
    ) u_sched (
        .clk    (clk),
        .rst    (rst),
        .due    (due),
        .skip   (cfg.skip),
        .req    (sample_req),
        .skipped(sample_skipped),
        .valid  (sample_valid),
        .overrun(overrun_cnt)
    );

endmodule

// File: rtl/pwm_trig_chk.sv
`timescale 1ns/1ps
module pwm_trig_chk #(
    parameter int BUSY_TICKS = 800,
    parameter int OVR_W      = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pwm_out,
    input logic             sample_req,
    input logic             sample_skipped,
    input logic             sample_valid,
    input logic [OVR_W-1:0] overrun_cnt
);

    logic [15:0] gap;

    always_ff @(posedge clk) begin
        if (rst)
            gap <= '1;
        else if (sample_req)
            gap <= 16'd1;
        else if (gap != '1)
            gap <= gap + 1'b1;
    end

    AST_REQ_GAP: assert property (@(posedge clk) disable iff (rst)
        sample_req |-> (gap >= 16'(BUSY_TICKS))); // R7
    AST_VALID_TIMING: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (gap == 16'(BUSY_TICKS))); // R9
    AST_SKIP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sample_req && sample_skipped)); // R5
    AST_SKIP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_skipped |=> !sample_skipped); // R5
    AST_REQ_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        sample_req |-> pwm_out); // R4
    AST_OVR_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((overrun_cnt == $past(overrun_cnt)) ||
                  (overrun_cnt == $past(overrun_cnt) + 1'b1))); // R8

endmodule

bind pwm_trig pwm_trig_chk #(
    .BUSY_TICKS(BUSY_TICKS),
    .OVR_W     (OVR_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pwm_out       (pwm_out),
    .sample_req    (sample_req),
    .sample_skipped(sample_skipped),
    .sample_valid  (sample_valid),
    .overrun_cnt   (overrun_cnt)
);

// File: tb/pwm_trig_tb.sv
`timescale 1ns/1ps
module pwm_trig_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] width_cmd = 16'd1000;
    logic [15:0] period_cmd = 16'd2000;
    logic        settle_en = 1'b0;
    logic        pwm_out, sample_req, sample_skipped, sample_valid;
    logic [7:0]  overrun_cnt;

    int checks = 0;
    int failures = 0;

    localparam int DEPTH = 8192;
    bit r_pwm [DEPTH];
    bit r_req [DEPTH];
    bit r_skp [DEPTH];
    bit r_val [DEPTH];

    // w, p, settle, exp_high, exp_period, exp_req_off, exp_skip_off
    localparam int NV = 9;
    localparam int VEC [NV][7] = '{
        '{1000, 2000, 0, 1030, 2000, 525, -1},
        '{   0, 2000, 0,  110, 2000,  65, -1},
        '{2000, 2000, 0, 1950, 2000, 985, -1},
        '{ 401, 1000, 1,  431, 1000,  -1, 225},
        '{ 600, 1000, 1,  630, 1000, 325, -1},
        '{  81,  400, 0,  111,  400,  65, -1},
        '{ 100,  100, 0,  110,  160,  65, -1},
        '{ 500, 1000, 1,  530, 1000, 275, -1},
        '{ 499, 1000, 1,  529, 1000,  -1, 274}
    };

    always #10 clk = ~clk;

    pwm_trig u_dut (
        .clk           (clk),
        .rst           (rst),
        .width_cmd     (width_cmd),
        .period_cmd    (period_cmd),
        .settle_en     (settle_en),
        .pwm_out       (pwm_out),
        .sample_req    (sample_req),
        .sample_skipped(sample_skipped),
        .sample_valid  (sample_valid),
        .overrun_cnt   (overrun_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold reset, check idle outputs, release; returns at cycle 0 of first period
    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 pwm low in reset", int'(pwm_out), 0);
        check("R1 strobes idle in reset",
              int'(sample_req) + int'(sample_skipped) + int'(sample_valid), 0);
        check("R1 overrun cleared", int'(overrun_cnt), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_cycles(input int n, input int chg_at, input int new_w);
        for (int c = 0; c < n; c++) begin
            if (c == chg_at) width_cmd = 16'(new_w);
            if (c < DEPTH) begin
                r_pwm[c] = pwm_out;
                r_req[c] = sample_req;
                r_skp[c] = sample_skipped;
                r_val[c] = sample_valid;
            end
            @(negedge clk);
        end
    endtask

    function automatic int count_high(input int from, input int len);
        int h = 0;
        for (int c = from; c < from + len; c++) h += int'(r_pwm[c]);
        return h;
    endfunction

    initial begin
        #3_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Table walk: R2 R3 R4 R5 R1
        for (int v = 0; v < NV; v++) begin
            int per, req_at, skp_at, nreq;
            width_cmd  = 16'(VEC[v][0]);
            period_cmd = 16'(VEC[v][1]);
            settle_en  = VEC[v][2][0];
            do_reset();
            per = VEC[v][4];
            run_cycles(per + 1, -1, 0);
            check("R1 first cycle high", int'(r_pwm[0]), 1);
            check("R2 R3 high time", count_high(0, per), VEC[v][3]);
            check("R2 R3 period end low", int'(r_pwm[per - 1]), 0);
            check("R2 R3 next rise", int'(r_pwm[per]), 1);
            req_at = -1; skp_at = -1; nreq = 0;
            for (int c = 0; c < per; c++) begin
                if (r_req[c]) begin req_at = c; nreq++; end
                if (r_skp[c]) skp_at = c;
            end
            check("R4 strobe offset", req_at, VEC[v][5]);
            check("R4 strobes per period", nreq, (VEC[v][5] >= 0) ? 1 : 0);
            check("R5 skip offset", skp_at, VEC[v][6]);
        end

        // R6: width change mid-period takes effect next period
        width_cmd = 16'd1000; period_cmd = 16'd2000; settle_en = 1'b0;
        do_reset();
        run_cycles(4000, 100, 200);
        check("R6 current period unchanged", count_high(0, 2000), 1030);
        check("R6 next period new width", count_high(2000, 2000), 230);

        // R7 R9: period 500, due at 125; drop at 625, issue at 1125
        width_cmd = 16'd200; period_cmd = 16'd500;
        do_reset();
        run_cycles(1200, -1, 0);
        check("R7 issued at 125", int'(r_req[125]), 1);
        check("R7 dropped at 625", int'(r_req[625]), 0);
        check("R7 issued at 1125", int'(r_req[1125]), 1);
        check("R7 overrun count", int'(overrun_cnt), 1);
        check("R9 valid at 925", int'(r_val[925]), 1);
        check("R9 valid low before", int'(r_val[924]), 0);
        check("R9 valid single cycle", int'(r_val[926]), 0);

        // Coincidence: period 800, window closes on the next request
        width_cmd = 16'd200; period_cmd = 16'd800;
        do_reset();
        run_cycles(1000, -1, 0);
        check("R7 request at window close", int'(r_req[925]), 1);
        check("R9 valid at same cycle", int'(r_val[925]), 1);
        check("R7 no overrun at boundary", int'(overrun_cnt), 0);

        // R8: saturation with period 160 (4 drops per 800 cycles)
        width_cmd = 16'd80; period_cmd = 16'd160;
        do_reset();
        run_cycles(8000, -1, 0);
        check("R8 partial count", int'(overrun_cnt), 40);
        run_cycles(60000, -1, 0);
        check("R8 saturated", int'(overrun_cnt), 255);
        run_cycles(2000, -1, 0);
        check("R8 holds at max", int'(overrun_cnt), 255);

        do_reset();
        check("R1 first cycle after reset high", int'(pwm_out), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule